// File: doc/BRIEF.md
# I2C Master Bit-Level Condition Engine

This block drives an I2C bus as its only master, one bus-level operation at a time. It drives SCL and SDA through active-high pull-down enables, as an open-drain pad needs, and it reads the wired SDA level back. A released line is taken to be pulled high by the bus. A byte layer above the block issues five operations through a valid/ready handshake: start condition, repeated start, stop condition, single-bit write and single-bit read. The block reports the end of each operation with a one-cycle done pulse. For reads it returns the SDA level it sampled.

Every bus phase lasts one of two programmable lengths, a low count or a high count. Both are derived from the system clock frequency and loaded from a speed selector. Each phase length is floor(clk_hz * ns / 1e9) + 1 clocks. Standard speed uses 4700 ns low and 4000 ns high. Fast speed uses 1300 ns low and 600 ns high. If a start condition finds SDA held low, the block first pulses SCL once so that a stuck target can let go of the line. It then proceeds with the start condition.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, `scl_low`, `sda_low`, `cmd_done`, `rd_bit` and `cfg_err` are 0, and standard timing is loaded.
- R2: With CLK_HZ = 50 MHz the low/high counts are 236/201 clocks at standard speed and 66/31 clocks at fast speed.
- R3: A `cfg_valid` cycle with `cfg_speed` 0 (standard) or 1 (fast) loads the matching counts and clears `cfg_err` on the next cycle. Codes 2 and 3 set `cfg_err` on the next cycle and leave the counts unchanged.
- R4: A start condition (op 0) that sees SDA high drives `sda_low` for the high count, with SCL left as it was. It then also drives `scl_low` for the low count.
- R5: A start condition that sees SDA low first drives `scl_low` for the low count. It then releases SCL for another low count and continues as in R4.
- R6: A repeated start (op 1) releases both lines for the high count and then for the low count. It then runs R4 or R5, depending on SDA at the end of that wait.
- R7: A stop condition (op 2) drives `sda_low` with SCL unchanged for the low count. It then releases SCL for two high counts, and finally releases SDA for the low count.
- R8: A write (op 3) drives `sda_low` = NOT `cmd_bit` and releases SCL for the high count. It then drives `scl_low` with the same SDA for the low count.
- R9: A read (op 4) releases both lines for the high count, and `rd_bit` takes the SDA level seen in the last cycle of that phase. It then drives `scl_low` for the low count. `rd_bit` holds its value until the next read.
- R10: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the operation ends. `cmd_done` is 1 for exactly the one cycle in which `cmd_ready` returns. Between commands both line drives hold their last value.
- R11: Op codes 5 to 7 are ignored: `cmd_ready` stays 1, no `cmd_done` occurs and both line drives stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Apply `cfg_speed` this cycle |
| cfg_speed | input | 2 | 0 standard, 1 fast, 2/3 rejected |
| cfg_err | output | 1 | Last speed request was rejected |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 start, 1 repeated start, 2 stop, 3 write, 4 read |
| cmd_bit | input | 1 | Bit to place on SDA for a write |
| cmd_ready | output | 1 | Idle and able to accept a command |
| cmd_done | output | 1 | One-cycle pulse at the end of an operation |
| rd_bit | output | 1 | SDA level captured by the last read |
| sda_in | input | 1 | Wired SDA level from the pad |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
The checker watches the handshake on every cycle. Done must fall in an idle cycle and last exactly one cycle, ready must drop after each accepted command, and the lines must stay still while idle or when an unknown op code arrives. It also checks the first-cycle line drive of write, read and stop, and the error flag that follows each speed request. The phase lengths, the choice between a pre-pulse and a direct start, the read sample point and the retained timing after a rejected speed code can only be shown by the bench scenarios. Those scenarios compare every cycle against a model with a stuck-low target on SDA, a released target, both speeds and a rejected code in between.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int CLK_HZ = 50_000_000,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_speed,
  output logic             cfg_err,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             cmd_ready,
  output logic             cmd_done,
  output logic             rd_bit,
  input  logic             sda_in,
  output logic             scl_low,
  output logic             sda_low
);

  localparam logic [CNT_W-1:0] STD_LO  = CNT_W'(64'(CLK_HZ) * 64'd4700 / 64'd1_000_000_000 + 64'd1);
  localparam logic [CNT_W-1:0] STD_HI  = CNT_W'(64'(CLK_HZ) * 64'd4000 / 64'd1_000_000_000 + 64'd1);
  localparam logic [CNT_W-1:0] FAST_LO = CNT_W'(64'(CLK_HZ) * 64'd1300 / 64'd1_000_000_000 + 64'd1);
  localparam logic [CNT_W-1:0] FAST_HI = CNT_W'(64'(CLK_HZ) * 64'd600  / 64'd1_000_000_000 + 64'd1);

  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_RSTRT = 3'd1;
  localparam logic [2:0] OP_STOP  = 3'd2;
  localparam logic [2:0] OP_WR    = 3'd3;
  localparam logic [2:0] OP_RD    = 3'd4;

  typedef enum logic [3:0] {
    P_IDLE, P_PRE_LO, P_PRE_HI, P_HOLD, P_SCL_DN,
    P_RS_HI, P_RS_SU,
    P_SP_LO, P_SP_HI, P_SP_SU, P_SP_BUF,
    P_WR_HI, P_WR_LO, P_RD_HI, P_RD_LO
  } phase_t;

  phase_t           phase, nxt, start_ph;
  logic [CNT_W-1:0] cnt, lo_q, hi_q;
  logic             fin, use_lo;

  assign cmd_ready = (phase == P_IDLE);
  wire accept = cmd_ready && cmd_valid && (cmd_op <= OP_RD);
  wire expire = (phase != P_IDLE) && (cnt == '0);
  assign start_ph = sda_in ? P_HOLD : P_PRE_LO;

  always_comb begin
    nxt = phase;
    fin = 1'b0;
    if (accept) begin
      case (cmd_op)
        OP_START: nxt = start_ph;
        OP_RSTRT: nxt = P_RS_HI;
        OP_STOP:  nxt = P_SP_LO;
        OP_WR:    nxt = P_WR_HI;
        default:  nxt = P_RD_HI;
      endcase
    end else if (expire) begin
      case (phase)
        P_PRE_LO: nxt = P_PRE_HI;
        P_PRE_HI: nxt = P_HOLD;
        P_HOLD:   nxt = P_SCL_DN;
        P_RS_HI:  nxt = P_RS_SU;
        P_RS_SU:  nxt = start_ph;
        P_SP_LO:  nxt = P_SP_HI;
        P_SP_HI:  nxt = P_SP_SU;
        P_SP_SU:  nxt = P_SP_BUF;
        P_WR_HI:  nxt = P_WR_LO;
        P_RD_HI:  nxt = P_RD_LO;
        default: begin
          nxt = P_IDLE;
          fin = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (nxt)
      P_PRE_LO, P_PRE_HI, P_SCL_DN, P_RS_SU,
      P_SP_LO, P_SP_BUF, P_WR_LO, P_RD_LO: use_lo = 1'b1;
      default:                              use_lo = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      cnt      <= '0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      cmd_done <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      cmd_done <= fin;
      if (phase == P_RD_HI && cnt == '0)
        rd_bit <= sda_in;
      if (accept || expire) begin
        phase <= nxt;
        cnt   <= (use_lo ? lo_q : hi_q) - 1'b1;
        case (nxt)
          P_PRE_LO, P_SCL_DN, P_WR_LO, P_RD_LO: scl_low <= 1'b1;
          P_PRE_HI, P_SP_HI:                    scl_low <= 1'b0;
          P_HOLD, P_SP_LO:                      sda_low <= 1'b1;
          P_SP_BUF:                             sda_low <= 1'b0;
          P_RS_HI, P_RD_HI: begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
          end
          P_WR_HI: begin
            scl_low <= 1'b0;
            sda_low <= ~cmd_bit;
          end
          default: ;
        endcase
      end else if (phase != P_IDLE) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= STD_LO;
      hi_q    <= STD_HI;
      cfg_err <= 1'b0;
    end else if (cfg_valid) begin
      case (cfg_speed)
        2'd0: begin
          lo_q    <= STD_LO;
          hi_q    <= STD_HI;
          cfg_err <= 1'b0;
        end
        2'd1: begin
          lo_q    <= FAST_LO;
          hi_q    <= FAST_HI;
          cfg_err <= 1'b0;
        end
        default: cfg_err <= 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic [1:0] cfg_speed,
  input logic       cfg_err,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cmd_bit,
  input logic       cmd_ready,
  input logic       cmd_done,
  input logic       scl_low,
  input logic       sda_low
);

  wire take = cmd_valid && cmd_ready;

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cmd_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op <= 3'd4) |=> !cmd_ready);

  assert_idle_lines_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> ($stable(scl_low) && $stable(sda_low)));

  assert_bad_op_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op > 3'd4) |=> (cmd_ready && !cmd_done && $stable(scl_low) && $stable(sda_low)));

  assert_cfg_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_speed > 2'd1) |=> cfg_err);

  assert_cfg_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_speed <= 2'd1) |=> !cfg_err);

  assert_stop_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 3'd2) |=> sda_low);

  assert_write_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 3'd3) |=> (!scl_low && (sda_low == !$past(cmd_bit))));

  assert_read_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 3'd4) |=> (!scl_low && !sda_low));

endmodule

bind i2c_bit_engine i2c_bit_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_speed(cfg_speed),
  .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
  .cmd_ready(cmd_ready), .cmd_done(cmd_done), .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/i2c_bit_engine_tb_top.sv
module i2c_bit_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [1:0] cfg_speed = 2'd0;
  logic       cfg_err;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       cmd_bit = 1'b0;
  logic       cmd_ready, cmd_done, rd_bit, sda_in, scl_low, sda_low;
  logic       target_hold = 1'b0;

  always #10 clk = ~clk;

  assign sda_in = ~(sda_low | target_hold);

  i2c_bit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_speed(cfg_speed),
    .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .rd_bit(rd_bit), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  int    expq[$];
  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    run = 1'b0;
  logic  m_scl = 1'b0, m_sda = 1'b0, m_err = 1'b0, m_rd = 1'b0;
  int    m_lo = 236, m_hi = 201;

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // per-cycle comparison of {ready, done, sda_low, scl_low} (R10 handshake)
  always @(negedge clk) begin
    int e;
    if (run) begin
      if (expq.size() > 0) begin
        e = expq.pop_front();
      end else begin
        e = 8 | (int'(m_sda) << 1) | int'(m_scl);
        chk(tag, int'(rd_bit), int'(m_rd), "rd_bit");
        chk(tag, int'(cfg_err), int'(m_err), "cfg_err");
      end
      chk(tag, {28'd0, cmd_ready, cmd_done, sda_low, scl_low}, e, "ready/done/sda/scl (R10)");
    end
  end

  task automatic ph(int n, logic s, logic d);
    for (int i = 0; i < n; i++) expq.push_back((int'(d) << 1) | int'(s));
    m_scl = s;
    m_sda = d;
  endtask

  task automatic m_start();
    if (m_sda || target_hold) begin
      ph(m_lo, 1'b1, m_sda);
      ph(m_lo, 1'b0, m_sda);
    end
    ph(m_hi, m_scl, 1'b1);
    ph(m_lo, 1'b1, 1'b1);
  endtask

  task automatic issue(int op, logic b, string r);
    @(negedge clk);
    tag = r;
    cmd_op = 3'(op);
    cmd_bit = b;
    cmd_valid = 1'b1;
    @(posedge clk);
    case (op)
      0: m_start();
      1: begin ph(m_hi, 1'b0, 1'b0); ph(m_lo, 1'b0, 1'b0); m_start(); end
      2: begin ph(m_lo, m_scl, 1'b1); ph(m_hi, 1'b0, 1'b1); ph(m_hi, 1'b0, 1'b1); ph(m_lo, 1'b0, 1'b0); end
      3: begin ph(m_hi, 1'b0, !b); ph(m_lo, 1'b1, !b); end
      default: begin ph(m_hi, 1'b0, 1'b0); ph(m_lo, 1'b1, 1'b0); m_rd = !target_hold; end
    endcase
    expq.push_back(8 | 4 | (int'(m_sda) << 1) | int'(m_scl));
    @(negedge clk);
    cmd_valid = 1'b0;
    wait (expq.size() == 0);
  endtask

  task automatic set_speed(int s, string r);
    @(negedge clk);
    tag = r;
    cfg_speed = 2'(s);
    cfg_valid = 1'b1;
    @(posedge clk);
    if (s == 0) begin m_lo = 236; m_hi = 201; m_err = 1'b0; end
    else if (s == 1) begin m_lo = 66; m_hi = 31; m_err = 1'b0; end
    else m_err = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);                 // R1 reset state
    issue(0, 1'b0, "R4");                      // start, standard timing (R2)
    issue(3, 1'b1, "R8");
    set_speed(1, "R3");
    issue(3, 1'b0, "R2");                      // fast timing
    set_speed(2, "R3");                        // rejected, fast kept
    issue(3, 1'b1, "R3");
    target_hold = 1'b1;
    issue(4, 1'b0, "R9");                      // reads 0
    target_hold = 1'b0;
    issue(4, 1'b0, "R9");                      // reads 1
    issue(1, 1'b0, "R6");                      // repeated start, no pre-pulse
    issue(3, 1'b0, "R8");
    issue(2, 1'b0, "R7");
    target_hold = 1'b1;
    issue(0, 1'b0, "R5");                      // stuck SDA, pre-pulse
    issue(1, 1'b0, "R6");                      // repeated start with pre-pulse
    target_hold = 1'b0;
    issue(2, 1'b0, "R7");
    @(negedge clk);
    tag = "R11";
    cmd_op = 3'd6;
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    set_speed(3, "R3");
    set_speed(0, "R3");
    issue(0, 1'b0, "R2");                      // back to standard timing
    issue(2, 1'b0, "R7");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule